// File: doc/BRIEF.md
# Serial-Bus Memory Initialization Sequencer

This block steps a chain of serially controlled memory devices through one part of their power-up bring-up. It never drives the serial wires itself. It hands a control-bus master one request at a time. Each request carries an opcode, a broadcast flag, a device number, a register address and a data word. The request stays on a valid/ready handshake until the master takes it.

After a start pulse, the sequencer first gives each device in the chain its own identification number. It then seeds the exit-timing, read-latency and row-to-column delay registers on all devices at once. Next comes a second reset, with test-register writes on either side of it. The two current-control registers are then loaded with the midpoints of their allowed ranges. Finally the sequencer issues a broadcast exit from powerdown and a read-domain fix command, and pulses `done`.

Top module: `mem_init_seq`

## Requirements
- R1: For N = min(`dev_count`, 32), the first N requests are unicast writes (`req_bcast`=0) to the identification register (default address 0x021). In request k, both `req_dev` and `req_data` equal k, for k = 0 to N-1 in increasing order. When N = 0, this phase is skipped.
- R2: Next come three broadcast writes with `req_dev`=0, in this order: powerdown-exit timing A (0x044 ← 0x0007), powerdown-exit timing B (0x045 ← 0x0003) and nap-exit timing (0x046 ← 0x0012). Each is issued exactly once.
- R3: Next, both read-latency registers (0x060, then 0x061) get a broadcast write of the parameter `LAT_MIN` (default 0x0008).
- R4: Next, the row-to-column delay register (0x062) gets a broadcast write of `trcd` − `RCD_OFFSET` (default 2). The result saturates at 0 when `trcd` ≤ `RCD_OFFSET`.
- R5: Next, the high test register (0x0F0) is written with 0x0004, and after it the low test register (0x0F1) is written with 0x0040.
- R6: Next comes the reset-set command, directly followed by the reset-clear command. After them, the low test register and then the high test register are each written with 0.
- R7: Next, current-control A (0x030) and then current-control B (0x031) get a broadcast write of floor((min + max) / 2). The sum is formed without overflow and the result is zero-extended.
- R8: The last two requests are the broadcast powerdown-exit command and then the read-domain fix command.
- R9: While `req_valid` is high and `req_ready` is low, every request field stays unchanged. Each accepted handshake advances the sequence by exactly one request.
- R10: `done` is high for exactly one cycle: the cycle after the final command is accepted. `req_valid` is low in that cycle and stays low afterwards.
- R11: A `start` pulse that arrives while a sequence is running has no effect on the requests. The sequence neither restarts nor produces extra requests.
- R12: A synchronous `rst` leaves the block idle, with `req_valid` and `done` low, until the next `start`.
- R13: Opcode encoding on `req_op`: 0 register write, 1 reset-set, 2 reset-clear, 3 powerdown-exit, 4 read-domain fix. Commands (opcodes 1–4) carry `req_bcast`=1 and `req_dev`, `req_addr` and `req_data` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that begins the sequence from idle |
| dev_count | input | 6 | Number of devices in the chain (clamped to 32) |
| trcd | input | TRCD_W | System row-to-column delay setting |
| cc_a_min | input | CC_W | Lower bound for current-control A |
| cc_a_max | input | CC_W | Upper bound for current-control A |
| cc_b_min | input | CC_W | Lower bound for current-control B |
| cc_b_max | input | CC_W | Upper bound for current-control B |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Bus master accepts the request |
| req_op | output | 3 | Request opcode (R13) |
| req_bcast | output | 1 | Request goes to all devices |
| req_dev | output | 5 | Target device number |
| req_addr | output | ADDR_W | Register address |
| req_data | output | DATA_W | Write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench covers these corner cases:
- An empty chain. A design that mishandled it would issue a stray identification write or underflow its device counter.
- An oversized count. Without the clamp, numbering would wrap past 31.
- A delay input at and below the offset. Without saturation, the delay write would underflow to a large value.
- Current-control bounds at the top of the range. A narrow adder would overflow and write a small midpoint.
- Steady backpressure. A design that advanced without a handshake would skip requests; one that changed fields early would corrupt them.
- A stray start pulse during a run. A design that obeyed it would restart the identification phase.
- A reset in the middle of the sequence. The design must return to idle and not resume the old run.

// File: rtl/imi_pkg.sv
package imi_pkg;

   typedef enum logic [2:0] {
      OP_WREG    = 3'd0,
      OP_RST_SET = 3'd1,
      OP_RST_CLR = 3'd2,
      OP_PD_EXIT = 3'd3,
      OP_DOM_FIX = 3'd4
   } imi_op_e;

   typedef enum logic [4:0] {
      ST_ID       = 5'd0,
      ST_PDX_A    = 5'd1,
      ST_PDX_B    = 5'd2,
      ST_NAP      = 5'd3,
      ST_LAT0     = 5'd4,
      ST_LAT1     = 5'd5,
      ST_RCD      = 5'd6,
      ST_TST_HI_A = 5'd7,
      ST_TST_LO_A = 5'd8,
      ST_RST_SET  = 5'd9,
      ST_RST_CLR  = 5'd10,
      ST_TST_LO_Z = 5'd11,
      ST_TST_HI_Z = 5'd12,
      ST_CUR_A    = 5'd13,
      ST_CUR_B    = 5'd14,
      ST_PD_EXIT  = 5'd15,
      ST_FIX      = 5'd16
   } imi_step_e;

   localparam int unsigned MAX_DEVS   = 32;
   localparam int unsigned DEV_W      = 5;
   localparam logic [15:0] TST_HI_ARM = 16'h0004;
   localparam logic [15:0] TST_LO_ARM = 16'h0040;

endpackage

// File: rtl/imi_midpoint.sv
module imi_midpoint #(
   parameter int unsigned W = 7
) (
   input  logic [W-1:0] lo,
   input  logic [W-1:0] hi,
   output logic [W-1:0] mid
);
   localparam int unsigned SUM_W = W + 1;

   logic [SUM_W-1:0] sum;

   assign sum = SUM_W'(lo) + SUM_W'(hi);
   assign mid = sum[SUM_W-1:1];

endmodule

// File: rtl/imi_step_table.sv
module imi_step_table
   import imi_pkg::*;
#(
   parameter int unsigned     ADDR_W     = 12,
   parameter int unsigned     DATA_W     = 16,
   parameter int unsigned     TRCD_W     = 8,
   parameter int unsigned     CC_W       = 7,
   parameter int unsigned     RCD_OFFSET = 2,
   parameter logic [ADDR_W-1:0] A_ID     = 12'h021,
   parameter logic [ADDR_W-1:0] A_PDX_A  = 12'h044,
   parameter logic [ADDR_W-1:0] A_PDX_B  = 12'h045,
   parameter logic [ADDR_W-1:0] A_NAP    = 12'h046,
   parameter logic [ADDR_W-1:0] A_LAT0   = 12'h060,
   parameter logic [ADDR_W-1:0] A_LAT1   = 12'h061,
   parameter logic [ADDR_W-1:0] A_RCD    = 12'h062,
   parameter logic [ADDR_W-1:0] A_TST_HI = 12'h0F0,
   parameter logic [ADDR_W-1:0] A_TST_LO = 12'h0F1,
   parameter logic [ADDR_W-1:0] A_CUR_A  = 12'h030,
   parameter logic [ADDR_W-1:0] A_CUR_B  = 12'h031,
   parameter logic [DATA_W-1:0] V_PDX_A  = 16'h0007,
   parameter logic [DATA_W-1:0] V_PDX_B  = 16'h0003,
   parameter logic [DATA_W-1:0] V_NAP    = 16'h0012,
   parameter logic [DATA_W-1:0] LAT_MIN  = 16'h0008
) (
   input  imi_step_e          step,
   input  logic [DEV_W-1:0]   dev_idx,
   input  logic [TRCD_W-1:0]  trcd,
   input  logic [CC_W-1:0]    mid_a,
   input  logic [CC_W-1:0]    mid_b,
   output imi_op_e            op,
   output logic               bcast,
   output logic [DEV_W-1:0]   dev,
   output logic [ADDR_W-1:0]  addr,
   output logic [DATA_W-1:0]  data
);
   logic [TRCD_W-1:0] rcd_val;

   if (RCD_OFFSET == 0) begin : g_rcd_pass
      assign rcd_val = trcd;
   end else begin : g_rcd_sub
      localparam logic [TRCD_W-1:0] OFS = TRCD_W'(RCD_OFFSET);
      assign rcd_val = (trcd > OFS) ? (trcd - OFS) : '0;
   end

   always_comb begin
      op    = OP_WREG;
      bcast = 1'b1;
      dev   = '0;
      addr  = '0;
      data  = '0;
      case (step)
         ST_ID: begin
            bcast = 1'b0;
            dev   = dev_idx;
            addr  = A_ID;
            data  = DATA_W'(dev_idx);
         end
         ST_PDX_A:    begin addr = A_PDX_A;  data = V_PDX_A; end
         ST_PDX_B:    begin addr = A_PDX_B;  data = V_PDX_B; end
         ST_NAP:      begin addr = A_NAP;    data = V_NAP; end
         ST_LAT0:     begin addr = A_LAT0;   data = LAT_MIN; end
         ST_LAT1:     begin addr = A_LAT1;   data = LAT_MIN; end
         ST_RCD:      begin addr = A_RCD;    data = DATA_W'(rcd_val); end
         ST_TST_HI_A: begin addr = A_TST_HI; data = DATA_W'(TST_HI_ARM); end
         ST_TST_LO_A: begin addr = A_TST_LO; data = DATA_W'(TST_LO_ARM); end
         ST_RST_SET:  op = OP_RST_SET;
         ST_RST_CLR:  op = OP_RST_CLR;
         ST_TST_LO_Z: addr = A_TST_LO;
         ST_TST_HI_Z: addr = A_TST_HI;
         ST_CUR_A:    begin addr = A_CUR_A;  data = DATA_W'(mid_a); end
         ST_CUR_B:    begin addr = A_CUR_B;  data = DATA_W'(mid_b); end
         ST_PD_EXIT:  op = OP_PD_EXIT;
         ST_FIX:      op = OP_DOM_FIX;
         default:     op = OP_WREG;
      endcase
   end

endmodule

// File: rtl/imi_step_ctrl.sv
module imi_step_ctrl
   import imi_pkg::*;
#(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [CNT_W-1:0] dev_count,
   input  logic             hs,
   output logic             running,
   output imi_step_e        step,
   output logic [DEV_W-1:0] dev_idx,
   output logic             done
);
   localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(MAX_DEVS);

   logic [CNT_W-1:0] cnt_clamped;
   logic [DEV_W-1:0] dev_last;

   assign cnt_clamped = (dev_count > CNT_CAP) ? CNT_CAP : dev_count;

   always_ff @(posedge clk) begin
      if (rst) begin
         running  <= 1'b0;
         step     <= ST_ID;
         dev_idx  <= '0;
         dev_last <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!running) begin
            if (start) begin
               running  <= 1'b1;
               dev_idx  <= '0;
               dev_last <= DEV_W'(cnt_clamped - CNT_W'(1));
               step     <= (cnt_clamped == '0) ? ST_PDX_A : ST_ID;
            end
         end else if (hs) begin
            if (step == ST_ID && dev_idx != dev_last) begin
               dev_idx <= dev_idx + DEV_W'(1);
            end else if (step == ST_FIX) begin
               running <= 1'b0;
               done    <= 1'b1;
            end else begin
               step <= imi_step_e'(step + 5'd1);
            end
         end
      end
   end

   // R11
   start_ignore_chk: assert property (@(posedge clk) disable iff (rst)
      running && start && !hs |=> running && $stable(step) && $stable(dev_idx));

endmodule

// File: rtl/mem_init_seq.sv
module mem_init_seq
   import imi_pkg::*;
#(
   parameter int unsigned     ADDR_W     = 12,
   parameter int unsigned     DATA_W     = 16,
   parameter int unsigned     TRCD_W     = 8,
   parameter int unsigned     CC_W       = 7,
   parameter int unsigned     RCD_OFFSET = 2,
   parameter logic [ADDR_W-1:0] A_ID     = 12'h021,
   parameter logic [ADDR_W-1:0] A_PDX_A  = 12'h044,
   parameter logic [ADDR_W-1:0] A_PDX_B  = 12'h045,
   parameter logic [ADDR_W-1:0] A_NAP    = 12'h046,
   parameter logic [ADDR_W-1:0] A_LAT0   = 12'h060,
   parameter logic [ADDR_W-1:0] A_LAT1   = 12'h061,
   parameter logic [ADDR_W-1:0] A_RCD    = 12'h062,
   parameter logic [ADDR_W-1:0] A_TST_HI = 12'h0F0,
   parameter logic [ADDR_W-1:0] A_TST_LO = 12'h0F1,
   parameter logic [ADDR_W-1:0] A_CUR_A  = 12'h030,
   parameter logic [ADDR_W-1:0] A_CUR_B  = 12'h031,
   parameter logic [DATA_W-1:0] V_PDX_A  = 16'h0007,
   parameter logic [DATA_W-1:0] V_PDX_B  = 16'h0003,
   parameter logic [DATA_W-1:0] V_NAP    = 16'h0012,
   parameter logic [DATA_W-1:0] LAT_MIN  = 16'h0008
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [5:0]        dev_count,
   input  logic [TRCD_W-1:0] trcd,
   input  logic [CC_W-1:0]   cc_a_min,
   input  logic [CC_W-1:0]   cc_a_max,
   input  logic [CC_W-1:0]   cc_b_min,
   input  logic [CC_W-1:0]   cc_b_max,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [2:0]        req_op,
   output logic              req_bcast,
   output logic [4:0]        req_dev,
   output logic [ADDR_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_data,
   output logic              done
);
   localparam int unsigned N_CC = 2;

   if (DATA_W < 16) begin : g_bad_data_w
      $error("DATA_W must hold the 16-bit test patterns");
   end
   if (TRCD_W > DATA_W || CC_W > DATA_W) begin : g_bad_field_w
      $error("TRCD_W and CC_W must fit in DATA_W");
   end
   if (DATA_W < DEV_W) begin : g_bad_dev_w
      $error("DATA_W must hold a device number");
   end

   logic            running;
   logic            hs;
   imi_step_e       step;
   logic [DEV_W-1:0] dev_idx;
   imi_op_e         op;
   logic [CC_W-1:0] cc_lo  [N_CC];
   logic [CC_W-1:0] cc_hi  [N_CC];
   logic [CC_W-1:0] cc_mid [N_CC];

   assign cc_lo[0] = cc_a_min;
   assign cc_hi[0] = cc_a_max;
   assign cc_lo[1] = cc_b_min;
   assign cc_hi[1] = cc_b_max;

   for (genvar g = 0; g < N_CC; g++) begin : g_mid
      imi_midpoint #(.W(CC_W)) u_mid (
         .lo  (cc_lo[g]),
         .hi  (cc_hi[g]),
         .mid (cc_mid[g])
      );
   end

   assign hs = running && req_ready;

   imi_step_ctrl #(.CNT_W(6)) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .start     (start),
      .dev_count (dev_count),
      .hs        (hs),
      .running   (running),
      .step      (step),
      .dev_idx   (dev_idx),
      .done      (done)
   );

   imi_step_table #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TRCD_W(TRCD_W), .CC_W(CC_W),
      .RCD_OFFSET(RCD_OFFSET),
      .A_ID(A_ID), .A_PDX_A(A_PDX_A), .A_PDX_B(A_PDX_B), .A_NAP(A_NAP),
      .A_LAT0(A_LAT0), .A_LAT1(A_LAT1), .A_RCD(A_RCD),
      .A_TST_HI(A_TST_HI), .A_TST_LO(A_TST_LO),
      .A_CUR_A(A_CUR_A), .A_CUR_B(A_CUR_B),
      .V_PDX_A(V_PDX_A), .V_PDX_B(V_PDX_B), .V_NAP(V_NAP), .LAT_MIN(LAT_MIN)
   ) u_table (
      .step    (step),
      .dev_idx (dev_idx),
      .trcd    (trcd),
      .mid_a   (cc_mid[0]),
      .mid_b   (cc_mid[1]),
      .op      (op),
      .bcast   (req_bcast),
      .dev     (req_dev),
      .addr    (req_addr),
      .data    (req_data)
   );

   assign req_valid = running;
   assign req_op    = op;

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (rst)
      req_valid && !req_ready |=> req_valid && $stable(req_op) && $stable(req_bcast)
         && $stable(req_dev) && $stable(req_addr) && $stable(req_data));

   // R6
   reset_pair_chk: assert property (@(posedge clk) disable iff (rst)
      req_valid && req_ready && req_op == OP_RST_SET |=> req_valid && req_op == OP_RST_CLR);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> !req_valid);

   // R10
   final_done_chk: assert property (@(posedge clk) disable iff (rst)
      req_valid && req_ready && req_op == OP_DOM_FIX |=> done);

   // R12
   reset_idle_chk: assert property (@(posedge clk)
      rst |=> !req_valid && !done);

endmodule

// File: tb/mem_init_seq_test.sv
module mem_init_seq_test;

   localparam int RCD_OFS = 2;

   typedef struct {
      logic [2:0]  op;
      logic        b;
      logic [4:0]  d;
      logic [11:0] a;
      logic [15:0] v;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [5:0]  dev_count = '0;
   logic [7:0]  trcd = '0;
   logic [6:0]  cc_a_min = '0, cc_a_max = '0, cc_b_min = '0, cc_b_max = '0;
   logic        req_valid;
   logic        req_ready = 1'b1;
   logic [2:0]  req_op;
   logic        req_bcast;
   logic [4:0]  req_dev;
   logic [11:0] req_addr;
   logic [15:0] req_data;
   logic        done;

   int  checks = 0;
   int  failures = 0;
   bit  mon_en = 1'b0;
   bit  bp_mode = 1'b0;
   bit  exp_done = 1'b0;
   bit  have_prev = 1'b0;
   bit  finished = 1'b0;
   int  cyc = 0;
   item_t exp_q[$];
   item_t e;
   item_t p;

   always #5 clk = ~clk;

   mem_init_seq uut (
      .clk(clk), .rst(rst), .start(start), .dev_count(dev_count), .trcd(trcd),
      .cc_a_min(cc_a_min), .cc_a_max(cc_a_max), .cc_b_min(cc_b_min), .cc_b_max(cc_b_max),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_bcast(req_bcast), .req_dev(req_dev), .req_addr(req_addr),
      .req_data(req_data), .done(done)
   );

   task automatic chk(bit ok, string tag, string msg);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: %s", tag, msg);
      end
   endtask

   task automatic push(int op, int b, int d, int a, int v, string tag);
      item_t it;
      it.op = 3'(op); it.b = 1'(b); it.d = 5'(d); it.a = 12'(a); it.v = 16'(v); it.tag = tag;
      exp_q.push_back(it);
   endtask

   task automatic build(int cnt, int tr, int al, int ah, int bl, int bh);
      int n = (cnt > 32) ? 32 : cnt;
      for (int i = 0; i < n; i++) push(0, 0, i, 'h021, i, "R1");
      push(0, 1, 0, 'h044, 'h0007, "R2");
      push(0, 1, 0, 'h045, 'h0003, "R2");
      push(0, 1, 0, 'h046, 'h0012, "R2");
      push(0, 1, 0, 'h060, 'h0008, "R3");
      push(0, 1, 0, 'h061, 'h0008, "R3");
      push(0, 1, 0, 'h062, (tr > RCD_OFS) ? tr - RCD_OFS : 0, "R4");
      push(0, 1, 0, 'h0F0, 'h0004, "R5");
      push(0, 1, 0, 'h0F1, 'h0040, "R5");
      push(1, 1, 0, 0, 0, "R6 R13");
      push(2, 1, 0, 0, 0, "R6 R13");
      push(0, 1, 0, 'h0F1, 0, "R6");
      push(0, 1, 0, 'h0F0, 0, "R6");
      push(0, 1, 0, 'h030, (al + ah) / 2, "R7");
      push(0, 1, 0, 'h031, (bl + bh) / 2, "R7");
      push(3, 1, 0, 0, 0, "R8 R13");
      push(4, 1, 0, 0, 0, "R8 R13");
   endtask

   // ready driver: always ready, or stalls one cycle in three
   always @(negedge clk) begin
      cyc++;
      req_ready = (bp_mode == 1'b0) ? 1'b1 : ((cyc % 3) != 1);
   end

   // monitor / scoreboard
   always begin
      @(negedge clk);
      #1;
      if (!mon_en) begin
         have_prev = 1'b0;
         exp_done = 1'b0;
      end else begin
         if (exp_done) begin
            chk(done === 1'b1 && req_valid === 1'b0, "R10",
                $sformatf("done=%0b valid=%0b exp done=1 valid=0", done, req_valid));
            exp_done = 1'b0;
         end else if (done === 1'b1) begin
            chk(1'b0, "R10", "done=1 exp 0");
         end
         if (have_prev) begin
            chk(req_valid && req_op == p.op && req_bcast == p.b && req_dev == p.d
                && req_addr == p.a && req_data == p.v, "R9",
                $sformatf("held op=%0d addr=%h data=%h exp op=%0d addr=%h data=%h",
                          req_op, req_addr, req_data, p.op, p.a, p.v));
            have_prev = 1'b0;
         end
         if (req_valid && !req_ready) begin
            p.op = req_op; p.b = req_bcast; p.d = req_dev; p.a = req_addr; p.v = req_data;
            have_prev = 1'b1;
         end
         if (req_valid && req_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R11", $sformatf("extra request op=%0d addr=%h exp none",
                                          req_op, req_addr));
            end else begin
               e = exp_q.pop_front();
               chk(req_op == e.op && req_bcast == e.b && req_dev == e.d
                   && req_addr == e.a && req_data == e.v, e.tag,
                   $sformatf("op=%0d b=%0b dev=%0d addr=%h data=%h exp op=%0d b=%0b dev=%0d addr=%h data=%h",
                             req_op, req_bcast, req_dev, req_addr, req_data,
                             e.op, e.b, e.d, e.a, e.v));
               if (exp_q.size() == 0) exp_done = 1'b1;
            end
         end
      end
   end

   task automatic run(int cnt, int tr, int al, int ah, int bl, int bh, bit bp, int glitch);
      @(negedge clk);
      bp_mode = bp;
      dev_count = 6'(cnt); trcd = 8'(tr);
      cc_a_min = 7'(al); cc_a_max = 7'(ah); cc_b_min = 7'(bl); cc_b_max = 7'(bh);
      build(cnt, tr, al, ah, bl, bh);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (glitch > 0) begin
         // R11: stray start during the run
         repeat (glitch) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      wait (exp_q.size() == 0);
      repeat (5) @(negedge clk);
      #2;
      chk(req_valid === 1'b0, "R10", $sformatf("valid=%0b after end exp 0", req_valid));
   endtask

   task automatic finish_up();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog", "run hung, exp completion");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      #2;
      // R12: reset state
      chk(req_valid === 1'b0 && done === 1'b0, "R12",
          $sformatf("valid=%0b done=%0b exp 0 0", req_valid, done));
      @(negedge clk);
      rst = 1'b0;
      mon_en = 1'b1;
      repeat (2) @(negedge clk);
      #2;
      chk(req_valid === 1'b0, "R12", $sformatf("idle valid=%0b exp 0", req_valid));

      run(3, 9, 3, 8, 10, 21, 1'b0, 0);        // R1 R4 R7 basic
      run(0, 1, 127, 127, 0, 1, 1'b1, 0);      // R1 empty chain, R4 saturate, R7 top range
      run(40, 2, 0, 127, 126, 127, 1'b1, 10);  // R1 clamp, R4 boundary, R11 stray start

      // R12: reset mid-run
      @(negedge clk);
      bp_mode = 1'b0;
      dev_count = 6'd1;
      build(1, 5, 1, 2, 3, 4);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      mon_en = 1'b0;
      rst = 1'b1;
      exp_q.delete();
      repeat (2) @(negedge clk);
      #2;
      chk(req_valid === 1'b0 && done === 1'b0, "R12",
          $sformatf("in reset valid=%0b done=%0b exp 0 0", req_valid, done));
      @(negedge clk);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      #2;
      chk(req_valid === 1'b0 && done === 1'b0, "R12",
          $sformatf("after reset valid=%0b done=%0b exp 0 0", req_valid, done));
      mon_en = 1'b1;

      run(2, 20, 5, 6, 0, 0, 1'b1, 0);         // recovery after reset
      finish_up();
   end

endmodule